// File: doc/BRIEF.md
# Interleave Host-to-Device Address Decoder

This block turns a host-side address offset into the offset seen by one memory device in an interleave set, and also reports which member of the set owns that address. The set shape comes with each request as two small codes. One code gives the number of ways. The other gives the interleave granularity, which is the size of each contiguous chunk. Power-of-two set sizes are handled by bit slicing and answer on the next cycle. Three-, six- and twelve-way sets need a true division of the upper address bits by three. That division runs on a serial restoring divider, and the block reports busy while it works.

Requests are qualified by a valid strobe. Each accepted request produces exactly one response strobe, which carries the device offset, the position and an error flag. A request with an unsupported way code or granularity code is answered at once with the error flag, an all-ones offset and position zero. The base-address subtraction and any XOR remapping are done before this block.

Top module: `ilv_h2d_decoder`

## Requirements
- R1: Legal way codes are 0,1,2,3,4 (1,2,4,8,16 ways) and 8,9,10 (3,6,12 ways). Any other way code gives rsp_err=1, rsp_dpa all ones and rsp_pos=0.
- R2: Legal granularity codes are 0 to 6. A granularity code of 7 or more gives rsp_err=1, rsp_dpa all ones and rsp_pos=0.
- R3: For every legal request, bits [g+7:0] of the device offset equal the same bits of the host offset, where g is the granularity code.
- R4: For way code w below 8, device offset bits above g+7 equal host offset >> (g+8+w), placed back at bit g+8.
- R5: For way code w below 8, the position is the w-bit field of the host offset that starts at bit g+8. Way code 0 gives position 0.
- R6: For way codes 8/9/10, device offset bits above g+7 equal (host offset >> (g+w)) / 3, placed at bit g+8. The result is truncated to the address width.
- R7: For way codes 8/9/10, the position is (host offset >> (g+8)) modulo 3, 6 or 12.
- R8: An illegal or power-of-two request is answered in the cycle after acceptance, with busy staying low. A 3/6/12-way request raises busy for exactly ADDR_W+1 cycles after acceptance, and its response comes in the cycle busy falls.
- R9: A request presented while busy is high is not accepted. It produces no response and does not change the result in flight.
- R10: While reset is held and after it is released, busy and rsp_valid are low.
- R11: rsp_valid is a single-cycle strobe, one per accepted request. A request held valid over several idle cycles is accepted once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request strobe, taken when busy is low |
| req_hpa | input | ADDR_W | host address offset |
| req_eiw | input | EIW_W | encoded way count |
| req_eig | input | EIG_W | encoded granularity |
| busy | output | 1 | divider occupied, requests ignored |
| rsp_valid | output | 1 | response strobe |
| rsp_dpa | output | ADDR_W | device address offset |
| rsp_pos | output | POS_W | position in the interleave set |
| rsp_err | output | 1 | illegal way or granularity code |

## Verification
The hardest case to reach from the ports is a new request that arrives while the divider is working. This includes the edge where busy falls, when the block is still not allowed to accept. The stimulus launches a twelve-way request and then presents a stream of different power-of-two requests during the divider's run, including the final busy cycle. The cycle-level reference model expects none of them to be accepted. Division corners are reached with all-ones and mixed-pattern addresses at the largest granularity. These make the quotient fill the top of the address and leave every possible remainder.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  parameter int ILV_ADDR_W = 52;
  parameter int ILV_EIW_W  = 8;
  parameter int ILV_EIG_W  = 16;
  parameter int ILV_POS_W  = 4;
  parameter int ILV_SH_W   = 5;
  parameter int ILV_EIG_MAX = 6;
  parameter int ILV_POW2_MAX = 4;
  parameter int ILV_TRI_MIN  = 8;
  parameter int ILV_TRI_MAX  = 10;

  typedef enum logic [1:0] {
    MAP_BAD  = 2'd0,
    MAP_POW2 = 2'd1,
    MAP_TRI  = 2'd2
  } map_kind_e;

  // mask with the n lowest bits set, width fixed by the caller's truncation
  function automatic logic [63:0] low_ones(input int unsigned n);
    if (n == 0) return 64'd0;
    return ~(64'hFFFF_FFFF_FFFF_FFFF << n);
  endfunction
endpackage

// File: rtl/ilv_classify.sv
module ilv_classify
  import ilv_pkg::*;
#(
  parameter int EIW_W = ILV_EIW_W,
  parameter int EIG_W = ILV_EIG_W,
  parameter int SH_W  = ILV_SH_W
) (
  input  logic [EIW_W-1:0] eiw,
  input  logic [EIG_W-1:0] eig,
  output map_kind_e        kind,
  output logic [SH_W-1:0]  lo_w,
  output logic [SH_W-1:0]  hi_sh,
  output logic [2:0]       p2_w,
  output logic [1:0]       tri_k
);
  logic eig_ok;

  always_comb begin
    eig_ok = (eig <= EIG_W'(ILV_EIG_MAX));
    if (!eig_ok)
      kind = MAP_BAD;
    else if (eiw <= EIW_W'(ILV_POW2_MAX))
      kind = MAP_POW2;
    else if (eiw >= EIW_W'(ILV_TRI_MIN) && eiw <= EIW_W'(ILV_TRI_MAX))
      kind = MAP_TRI;
    else
      kind = MAP_BAD;
    lo_w  = SH_W'(eig[2:0]) + SH_W'(8);
    p2_w  = eiw[2:0];
    tri_k = eiw[1:0];
    hi_sh = lo_w + SH_W'(tri_k);
  end
endmodule

// File: rtl/ilv_pow2_map.sv
module ilv_pow2_map
  import ilv_pkg::*;
#(
  parameter int ADDR_W = ILV_ADDR_W,
  parameter int POS_W  = ILV_POS_W,
  parameter int SH_W   = ILV_SH_W
) (
  input  logic [ADDR_W-1:0] hpa,
  input  logic [SH_W-1:0]   lo_w,
  input  logic [2:0]        w,
  output logic [ADDR_W-1:0] dpa,
  output logic [POS_W-1:0]  pos
);
  logic [ADDR_W-1:0] keep_lo, cut_hi, sel_mask;

  always_comb begin
    keep_lo  = ADDR_W'(low_ones(int'(lo_w)));
    cut_hi   = ADDR_W'(low_ones(int'(lo_w) + int'(w)));
    sel_mask = ADDR_W'(low_ones(int'(w)));
    dpa = ((hpa & ~cut_hi) >> w) | (hpa & keep_lo);
    pos = POS_W'((hpa >> lo_w) & sel_mask);
  end
endmodule

// File: rtl/ilv_div_const.sv
module ilv_div_const #(
  parameter int W       = 52,
  parameter int DIVISOR = 3,
  localparam int RW     = $clog2(DIVISOR),
  localparam int CW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [RW-1:0] rem
);
  logic [CW-1:0] cnt_q;
  logic [RW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem, quo[W-1]};
    fits  = (trial >= (RW+1)'(DIVISOR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= dividend;
        rem   <= '0;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        quo   <= {quo[W-2:0], fits};
        rem   <= fits ? RW'(trial - (RW+1)'(DIVISOR)) : RW'(trial);
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CW'(1));
      end
    end
  end
endmodule

// File: rtl/ilv_h2d_decoder.sv
module ilv_h2d_decoder
  import ilv_pkg::*;
#(
  parameter int ADDR_W = ILV_ADDR_W,
  parameter int EIW_W  = ILV_EIW_W,
  parameter int EIG_W  = ILV_EIG_W,
  parameter int POS_W  = ILV_POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_hpa,
  input  logic [EIW_W-1:0]  req_eiw,
  input  logic [EIG_W-1:0]  req_eig,
  output logic              busy,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_dpa,
  output logic [POS_W-1:0]  rsp_pos,
  output logic              rsp_err
);
  localparam int SH_W = ILV_SH_W;
  localparam int DIVR = 3;
  localparam int RW   = $clog2(DIVR);

  map_kind_e         cls_kind;
  logic [SH_W-1:0]   cls_lo_w, cls_hi_sh;
  logic [2:0]        cls_p2_w;
  logic [1:0]        cls_k;
  logic [ADDR_W-1:0] p2_dpa;
  logic [POS_W-1:0]  p2_pos;

  logic              accept, div_start, div_done;
  logic [ADDR_W-1:0] div_quo, div_in;
  logic [RW-1:0]     div_rem;

  logic              busy_q;
  logic [ADDR_W-1:0] hold_low;
  logic [SH_W-1:0]   hold_lo_w;
  logic [1:0]        hold_k, hold_sbits, req_sbits;
  logic [ADDR_W-1:0] tri_dpa;
  logic [POS_W-1:0]  tri_pos;

  ilv_classify #(.EIW_W(EIW_W), .EIG_W(EIG_W), .SH_W(SH_W)) u_cls (
    .eiw(req_eiw), .eig(req_eig), .kind(cls_kind), .lo_w(cls_lo_w),
    .hi_sh(cls_hi_sh), .p2_w(cls_p2_w), .tri_k(cls_k)
  );

  ilv_pow2_map #(.ADDR_W(ADDR_W), .POS_W(POS_W), .SH_W(SH_W)) u_p2 (
    .hpa(req_hpa), .lo_w(cls_lo_w), .w(cls_p2_w), .dpa(p2_dpa), .pos(p2_pos)
  );

  always_comb begin
    accept    = req_valid && !busy_q;
    div_start = accept && (cls_kind == MAP_TRI);
    div_in    = req_hpa >> cls_hi_sh;
    req_sbits = 2'(req_hpa >> cls_lo_w) & 2'((3'd1 << cls_k) - 3'd1);
    tri_dpa   = (div_quo << hold_lo_w) | hold_low;
    tri_pos   = (POS_W'(div_rem) << hold_k) | POS_W'(hold_sbits);
  end

  ilv_div_const #(.W(ADDR_W), .DIVISOR(DIVR)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_in),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_dpa    <= '0;
      rsp_pos    <= '0;
      rsp_err    <= 1'b0;
      hold_low   <= '0;
      hold_lo_w  <= '0;
      hold_k     <= '0;
      hold_sbits <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (div_done) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_dpa   <= tri_dpa;
        rsp_pos   <= tri_pos;
        rsp_err   <= 1'b0;
      end else if (accept) begin
        unique case (cls_kind)
          MAP_POW2: begin
            rsp_valid <= 1'b1;
            rsp_dpa   <= p2_dpa;
            rsp_pos   <= p2_pos;
            rsp_err   <= 1'b0;
          end
          MAP_TRI: begin
            busy_q     <= 1'b1;
            hold_low   <= req_hpa & ADDR_W'(low_ones(int'(cls_lo_w)));
            hold_lo_w  <= cls_lo_w;
            hold_k     <= cls_k;
            hold_sbits <= req_sbits;
          end
          default: begin
            rsp_valid <= 1'b1;
            rsp_dpa   <= '1;
            rsp_pos   <= '0;
            rsp_err   <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/ilv_h2d_decoder_chk.sv
module ilv_h2d_decoder_chk #(
  parameter int ADDR_W = 52,
  parameter int POS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] rsp_dpa,
  input logic [POS_W-1:0]  rsp_pos,
  input logic              div_start,
  input logic              div_done
);
  // R1
  err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> (rsp_dpa == '1) && (rsp_pos == '0));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !div_done |=> busy);

  // R8
  done_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> rsp_valid && !busy && !rsp_err);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !div_done |=> !rsp_valid);

  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !div_done);
endmodule

bind ilv_h2d_decoder ilv_h2d_decoder_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_dpa(rsp_dpa), .rsp_pos(rsp_pos),
  .div_start(div_start), .div_done(div_done)
);

// File: tb/ilv_h2d_decoder_tb.sv
module ilv_h2d_decoder_tb;
  localparam int AW   = 52;
  localparam int PW   = 4;
  localparam int SLOW = AW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_hpa = '0;
  logic [7:0]    req_eiw = '0;
  logic [15:0]   req_eig = '0;
  logic          busy, rsp_valid, rsp_err;
  logic [AW-1:0] rsp_dpa;
  logic [PW-1:0] rsp_pos;

  ilv_h2d_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hpa(req_hpa),
    .req_eiw(req_eiw), .req_eig(req_eig), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_dpa(rsp_dpa), .rsp_pos(rsp_pos), .rsp_err(rsp_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: plain integer arithmetic
  task automatic ref_calc(input logic [AW-1:0] hpa, input logic [7:0] w,
                          input logic [15:0] g, output logic [AW-1:0] dpa,
                          output logic [PW-1:0] pos, output bit err,
                          output bit slow, output string td, output string tp);
    longint unsigned h, ways, lowpart, up;
    h = 64'(hpa);
    slow = 1'b0;
    case (w)
      8'd0: ways = 1;  8'd1: ways = 2;  8'd2: ways = 4;  8'd3: ways = 8;
      8'd4: ways = 16; 8'd8: ways = 3;  8'd9: ways = 6;  8'd10: ways = 12;
      default: ways = 0;
    endcase
    if (g > 16'd6 || ways == 0) begin
      err = 1'b1; dpa = '1; pos = '0;
      td = (g > 16'd6) ? "R2 dpa" : "R1 dpa";
      tp = (g > 16'd6) ? "R2 pos" : "R1 pos";
    end else begin
      err = 1'b0;
      lowpart = h & ((64'd1 << (g + 8)) - 1);
      if (w < 8) begin
        up = (h >> (g + 8 + w)) << (g + 8);
        td = "R3/R4 dpa"; tp = "R5 pos";
      end else begin
        up = ((h >> (g + w)) / 3) << (g + 8);
        slow = 1'b1;
        td = "R3/R6 dpa"; tp = "R7 pos";
      end
      dpa = AW'(up | lowpart);
      pos = PW'((h >> (g + 8)) % ways);
    end
  endtask

  int            m_cnt = 0;
  bit            e_rv = 1'b0, e_err = 1'b0, p_err = 1'b0;
  logic [AW-1:0] e_dpa = '0, p_dpa = '0;
  logic [PW-1:0] e_pos = '0, p_pos = '0;
  string         e_td = "", e_tp = "", p_td = "", p_tp = "";

  always @(posedge clk) begin
    logic [AW-1:0] c_dpa;
    logic [PW-1:0] c_pos;
    bit c_err, c_slow;
    string c_td, c_tp;
    if (!rst_n) begin
      m_cnt = 0;
      e_rv  = 1'b0;
    end else begin
      e_rv = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          e_rv = 1'b1; e_dpa = p_dpa; e_pos = p_pos; e_err = p_err;
          e_td = p_td; e_tp = p_tp;
        end
      end else if (req_valid) begin
        ref_calc(req_hpa, req_eiw, req_eig, c_dpa, c_pos, c_err, c_slow, c_td, c_tp);
        if (c_slow) begin
          m_cnt = SLOW;
          p_dpa = c_dpa; p_pos = c_pos; p_err = c_err; p_td = c_td; p_tp = c_tp;
        end else begin
          e_rv = 1'b1; e_dpa = c_dpa; e_pos = c_pos; e_err = c_err;
          e_td = c_td; e_tp = c_tp;
        end
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy && !rsp_valid, "R10 reset outputs", {busy, rsp_valid}, 0);
    end else if (!finished) begin
      chk(busy === (m_cnt > 0), "R8 busy", 64'(busy), 64'(m_cnt > 0));
      chk(rsp_valid === e_rv, "R9/R11 rsp_valid", 64'(rsp_valid), 64'(e_rv));
      if (e_rv && rsp_valid) begin
        chk(rsp_err === e_err, {e_td, " err"}, 64'(rsp_err), 64'(e_err));
        chk(rsp_dpa === e_dpa, e_td, 64'(rsp_dpa), 64'(e_dpa));
        chk(rsp_pos === e_pos, e_tp, 64'(rsp_pos), 64'(e_pos));
      end
    end
  end

  task automatic send(input logic [AW-1:0] h, input logic [7:0] w,
                      input logic [15:0] g, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_hpa = h; req_eiw = w; req_eig = g;
    repeat (hold) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 after release
    chk(!busy && !rsp_valid, "R10 idle after reset", {busy, rsp_valid}, 0);

    // power-of-two sets, R3 R4 R5
    for (int w = 0; w <= 4; w++)
      for (int g = 0; g <= 6; g += 3) begin
        send(52'hA_BCDE_1234_5678, 8'(w), 16'(g), 1);
        send(52'h5_F00D_CAFE_3C3C, 8'(w), 16'(g), 1);
      end
    send('1, 8'd4, 16'd6, 1);
    settle();

    // illegal codes R1 R2
    send(52'h1234, 8'd5, 16'd0, 1);
    send(52'h1234, 8'd7, 16'd0, 1);
    send(52'h1234, 8'd11, 16'd0, 1);
    send(52'h1234, 8'hFF, 16'd0, 1);
    send(52'h1234, 8'd1, 16'd7, 1);
    send(52'h1234, 8'd2, 16'h10, 1);
    send(52'h1234, 8'd8, 16'hFFFF, 1);
    settle();

    // held valid: one response per cycle, R11
    send(52'h9_8765_4321_0FED, 8'd2, 16'd1, 4);
    settle();

    // 3/6/12-way sets R6 R7 R8
    for (int w = 8; w <= 10; w++)
      for (int g = 0; g <= 6; g += 3) begin
        send(52'hA_BCDE_1234_5678, 8'(w), 16'(g), 1);
        settle();
        send(52'h0_0000_0003_7F00, 8'(w), 16'(g), 1);
        settle();
      end
    send('1, 8'd10, 16'd6, 1);
    settle();
    send('1, 8'd8, 16'd0, 1);
    settle();

    // requests during busy are ignored, R9
    send(52'h7_1357_9BDF_2468, 8'd10, 16'd2, 1);
    send(52'h3_3333_3333_3333, 8'd3, 16'd0, SLOW - 1);
    settle();
    send(52'h2_4680_ACE1_3579, 8'd9, 16'd5, 1);
    send(52'hF_FFFF_0000_FFFF, 8'd5, 16'd0, 8);
    settle();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule